// File: doc/BRIEF.md
# Pixel Row Frame Sequencer

This block sets the row readout timing of a 640-row pixel matrix. It divides the fast readout clock in two stages. The first stage is a divide-by-10 in-pixel tick. The second is a divide-by-16 row tick, so the row pointer advances once every 160 readout cycles. At 160 MHz this gives a 1 MHz row rate and a 640 µs frame. Each pass through all rows forms one frame. The block counts frames and marks the start of every frame for the downstream data path.

Several identical chips on one ladder run from the same clock. An external alignment pulse brings all of them back to the same phase. The pulse clears the row pointer, both divider stages and the frame count in one cycle, and it announces a new frame. A configuration bit, modelled as a plain input, parks the sequencer at row 0 for as long as it is set.

Top module: `row_frame_seq`

## Requirements
- R1: While `rst` is high (synchronous, active high), and in the cycle after it is sampled, `row_idx` is 0, `frame_cnt` is 0, and `frame_start`, `frame_mark`, `pix_tick` and `row_tick` are all 0.
- R2: While running (neither `sync_in` nor `hold_idle` high), `pix_tick` is high for exactly one cycle in every 10. It is first high in the 10th cycle after an alignment event.
- R3: `row_tick` is high for exactly one cycle in every 160 running cycles and only together with `pix_tick`. `row_idx` increments in the cycle after each `row_tick` and is stable at all other running times.
- R4: `row_idx` stays in 0..639 and wraps from 639 to 0. In the first cycle that shows row 0 after the wrap, `frame_start` is high for exactly one cycle, and `frame_cnt` (16 bits, modulo 2^16) has increased by one in that same cycle.
- R5: A natural frame lasts 102400 cycles: a wrap-driven `frame_start` comes exactly 640 × 160 edges after the last edge at which reset, sync or hold was sampled.
- R6: `frame_mark` goes high together with `frame_start` and stays high for all of row 0 of that frame. It drops in the cycle `row_idx` becomes 1, and it is never high on any other row.
- R7: An edge that samples `sync_in` high makes the next cycle show `row_idx` 0, `frame_cnt` 0, and `frame_start` and `frame_mark` high. Both dividers restart from phase 0. Both ticks are low while `sync_in` is high.
- R8: An edge that samples `hold_idle` high (with `sync_in` low) makes the next cycle show `row_idx` 0, with `frame_start` and `frame_mark` low and `frame_cnt` unchanged. Ticks are low during hold. After release, stepping restarts from phase 0 with no frame strobe.
- R9: When `sync_in` and `hold_idle` are sampled high together, the sync behaviour of R7 applies.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast readout clock |
| rst | input | 1 | Synchronous active-high reset |
| sync_in | input | 1 | External ladder alignment pulse |
| hold_idle | input | 1 | Configuration bit: park at row 0 while high |
| row_idx | output | 10 | Selected row, 0..639 |
| frame_start | output | 1 | One-cycle strobe at the start of each frame |
| frame_cnt | output | 16 | Frames started since the last sync or reset |
| frame_mark | output | 1 | High during row 0 of a newly started frame |
| pix_tick | output | 1 | In-pixel rate strobe (readout clock / 10) |
| row_tick | output | 1 | Row rate strobe (readout clock / 160) |

## Verification
A wrong divider phase shows up on `pix_tick` within 10 cycles and on `row_tick` and `row_idx` within 160 cycles. That is why every output is compared with a timing model on every clock. A corrupted row pointer or a missed wrap shows at once as a `row_idx` mismatch. Its effect on `frame_start` and `frame_cnt` can stay hidden until the 102400-cycle frame boundary, so the run covers one full natural frame. Sync, hold and their overlap are each applied mid-frame. A state left behind by any of them is exposed in the very next cycle.

// File: rtl/rfs_pkg.sv
package rfs_pkg;

    localparam int DEF_ROWS    = 640;
    localparam int DEF_PIX_DIV = 10;
    localparam int DEF_ROW_DIV = 16;
    localparam int DEF_FCNT_W  = 16;

    typedef enum logic [1:0] {
        MODE_RUN  = 2'd0,
        MODE_HOLD = 2'd1,
        MODE_SYNC = 2'd2
    } seq_mode_e;

    function automatic seq_mode_e decode_mode(input logic sync, input logic hold);
        if (sync)
            return MODE_SYNC;
        else if (hold)
            return MODE_HOLD;
        else
            return MODE_RUN;
    endfunction

    function automatic int stage_width(input int modulus);
        return (modulus > 1) ? $clog2(modulus) : 1;
    endfunction

endpackage

// File: rtl/rfs_tick_div.sv
module rfs_tick_div #(
    parameter int MOD = 10
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic en,
    output logic term
);
    localparam int W = rfs_pkg::stage_width(MOD);
    localparam logic [W-1:0] LAST = W'(MOD - 1);

    logic [W-1:0] cnt;

    assign term = en && (cnt == LAST);

    always_ff @(posedge clk) begin
        if (rst || clr)
            cnt <= '0;
        else if (en)
            cnt <= term ? '0 : cnt + 1'b1;
    end
endmodule

// File: rtl/rfs_row_ptr.sv
module rfs_row_ptr #(
    parameter int ROWS  = 640,
    parameter int ROW_W = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             step,
    output logic [ROW_W-1:0] row,
    output logic             wrap
);
    localparam logic [ROW_W-1:0] LAST_ROW = ROW_W'(ROWS - 1);

    assign wrap = step && (row == LAST_ROW);

    always_ff @(posedge clk) begin
        if (rst || clr)
            row <= '0;
        else if (step)
            row <= wrap ? '0 : row + 1'b1;
    end
endmodule

// File: rtl/rfs_frame_track.sv
module rfs_frame_track
    import rfs_pkg::*;
#(
    parameter int FCNT_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  seq_mode_e         mode,
    input  logic              wrap,
    input  logic              row_step,
    output logic              strobe,
    output logic              mark,
    output logic [FCNT_W-1:0] fcnt
);
    typedef struct packed {
        logic [FCNT_W-1:0] fcnt;
        logic              strobe;
        logic              mark;
    } frame_state_t;

    frame_state_t cur, nxt;

    always_comb begin
        nxt = cur;
        nxt.strobe = 1'b0;
        unique case (mode)
            MODE_SYNC: begin
                nxt.fcnt   = '0;
                nxt.strobe = 1'b1;
                nxt.mark   = 1'b1;
            end
            MODE_HOLD: begin
                nxt.mark = 1'b0;
            end
            default: begin
                if (wrap) begin
                    nxt.fcnt   = cur.fcnt + 1'b1;
                    nxt.strobe = 1'b1;
                    nxt.mark   = 1'b1;
                end else if (row_step) begin
                    nxt.mark = 1'b0;
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)
            cur <= '0;
        else
            cur <= nxt;
    end

    assign strobe = cur.strobe;
    assign mark   = cur.mark;
    assign fcnt   = cur.fcnt;
endmodule

// File: rtl/row_frame_seq.sv
module row_frame_seq
    import rfs_pkg::*;
#(
    parameter int NUM_ROWS = DEF_ROWS,
    parameter int PIX_DIV  = DEF_PIX_DIV,
    parameter int ROW_DIV  = DEF_ROW_DIV,
    parameter int FCNT_W   = DEF_FCNT_W,
    parameter int ROW_W    = $clog2(NUM_ROWS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sync_in,
    input  logic              hold_idle,
    output logic [ROW_W-1:0]  row_idx,
    output logic              frame_start,
    output logic [FCNT_W-1:0] frame_cnt,
    output logic              frame_mark,
    output logic              pix_tick,
    output logic              row_tick
);
    localparam int NSTAGE = 2;

    seq_mode_e mode;
    logic      running;
    logic      clr_all;
    logic [NSTAGE:0] stage_en;
    logic      wrap;

    assign mode    = decode_mode(sync_in, hold_idle);
    assign running = (mode == MODE_RUN);
    assign clr_all = !running;

    assign stage_en[0] = running;

    for (genvar i = 0; i < NSTAGE; i++) begin : g_div
        localparam int MODV = (i == 0) ? PIX_DIV : ROW_DIV;
        rfs_tick_div #(.MOD(MODV)) u_div (
            .clk  (clk),
            .rst  (rst),
            .clr  (clr_all),
            .en   (stage_en[i]),
            .term (stage_en[i+1])
        );
    end

    assign pix_tick = stage_en[1];
    assign row_tick = stage_en[NSTAGE];

    rfs_row_ptr #(.ROWS(NUM_ROWS), .ROW_W(ROW_W)) u_row (
        .clk  (clk),
        .rst  (rst),
        .clr  (clr_all),
        .step (row_tick),
        .row  (row_idx),
        .wrap (wrap)
    );

    rfs_frame_track #(.FCNT_W(FCNT_W)) u_frame (
        .clk      (clk),
        .rst      (rst),
        .mode     (mode),
        .wrap     (wrap),
        .row_step (row_tick),
        .strobe   (frame_start),
        .mark     (frame_mark),
        .fcnt     (frame_cnt)
    );
endmodule

// File: rtl/row_frame_seq_chk.sv
module row_frame_seq_chk #(
    parameter int NUM_ROWS = 640,
    parameter int FCNT_W   = 16,
    parameter int ROW_W    = 10
) (
    input logic              clk,
    input logic              rst,
    input logic              sync_in,
    input logic              hold_idle,
    input logic [ROW_W-1:0]  row_idx,
    input logic              frame_start,
    input logic [FCNT_W-1:0] frame_cnt,
    input logic              frame_mark,
    input logic              pix_tick,
    input logic              row_tick
);
    localparam logic [ROW_W-1:0] LAST_ROW = ROW_W'(NUM_ROWS - 1);

    AST_ROW_RANGE: assert property (@(posedge clk) disable iff (rst)
        row_idx <= LAST_ROW); // R4

    AST_TICK_NEST: assert property (@(posedge clk) disable iff (rst)
        row_tick |-> pix_tick); // R3

    AST_ROW_STEP: assert property (@(posedge clk) disable iff (rst)
        (row_tick && !sync_in && !hold_idle) |=>
            (row_idx == (($past(row_idx) == LAST_ROW) ? '0 : $past(row_idx) + 1'b1))); // R3

    AST_ROW_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (!row_tick && !sync_in && !hold_idle) |=> $stable(row_idx)); // R3

    AST_STRB_ROW0: assert property (@(posedge clk) disable iff (rst)
        frame_start |-> (row_idx == '0)); // R4

    AST_STRB_SINGLE: assert property (@(posedge clk) disable iff (rst)
        frame_start |=> (!frame_start || $past(sync_in))); // R4

    AST_MARK_ROW0: assert property (@(posedge clk) disable iff (rst)
        frame_mark |-> (row_idx == '0)); // R6

    AST_SYNC_CLEAR: assert property (@(posedge clk) disable iff (rst)
        sync_in |=> (row_idx == '0 && frame_cnt == '0 && frame_start && frame_mark)); // R7

    AST_SYNC_NO_TICK: assert property (@(posedge clk) disable iff (rst)
        sync_in |-> (!pix_tick && !row_tick)); // R7

    AST_HOLD_PARK: assert property (@(posedge clk) disable iff (rst)
        (hold_idle && !sync_in) |=>
            (row_idx == '0 && !frame_start && !frame_mark && $stable(frame_cnt))); // R8
endmodule

bind row_frame_seq row_frame_seq_chk #(
    .NUM_ROWS (NUM_ROWS),
    .FCNT_W   (FCNT_W),
    .ROW_W    (ROW_W)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .sync_in     (sync_in),
    .hold_idle   (hold_idle),
    .row_idx     (row_idx),
    .frame_start (frame_start),
    .frame_cnt   (frame_cnt),
    .frame_mark  (frame_mark),
    .pix_tick    (pix_tick),
    .row_tick    (row_tick)
);

// File: tb/tb_row_frame_seq.sv
module tb_row_frame_seq;
    localparam int ROWS      = 640;
    localparam int PIXD      = 10;
    localparam int ROW_CYC   = 160;
    localparam int FRAME_CYC = ROWS * ROW_CYC;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sync_in = 1'b0;
    logic        hold_idle = 1'b0;
    logic [9:0]  row_idx;
    logic        frame_start;
    logic [15:0] frame_cnt;
    logic        frame_mark;
    logic        pix_tick;
    logic        row_tick;

    row_frame_seq dut (
        .clk         (clk),
        .rst         (rst),
        .sync_in     (sync_in),
        .hold_idle   (hold_idle),
        .row_idx     (row_idx),
        .frame_start (frame_start),
        .frame_cnt   (frame_cnt),
        .frame_mark  (frame_mark),
        .pix_tick    (pix_tick),
        .row_tick    (row_tick)
    );

    always #2 clk = ~clk;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s at %0t: actual %0d expected %0d", tag, $time, act, exp);
        end
    endtask

    // Behavioural timing model: cycles since last alignment.
    int          t = 0;
    logic [15:0] m_fr = '0;
    bit          m_fs = 1'b0;
    bit          m_mk = 1'b0;
    longint      cyc = 0;
    longint      align_cyc = 0;
    bit          edge_sync = 1'b0;
    bit          seen_edge = 1'b0;

    always @(posedge clk) begin
        cyc++;
        seen_edge = 1'b1;
        edge_sync = sync_in;
        if (rst) begin
            t = 0; m_fr = '0; m_fs = 0; m_mk = 0; align_cyc = cyc;
        end else if (sync_in) begin
            t = 0; m_fr = '0; m_fs = 1; m_mk = 1; align_cyc = cyc;
        end else if (hold_idle) begin
            t = 0; m_fs = 0; m_mk = 0; align_cyc = cyc;
        end else begin
            t++;
            m_fs = 0;
            if (t == FRAME_CYC) begin
                t = 0; m_fr = m_fr + 16'd1; m_fs = 1; m_mk = 1;
            end else if (t >= ROW_CYC) begin
                m_mk = 0;
            end
        end
    end

    always @(negedge clk) begin
        if (seen_edge && !done) begin
            automatic bit run = !rst && !sync_in && !hold_idle;
            automatic bit e_pix = run && (t % PIXD == PIXD - 1);
            automatic bit e_row = run && (t % ROW_CYC == ROW_CYC - 1);
            chk(pix_tick == e_pix, "R2 pix_tick", pix_tick, e_pix);
            chk(row_tick == e_row, "R3 row_tick", row_tick, e_row);
            chk(row_idx == 10'(t / ROW_CYC), "R3 row_idx", row_idx, t / ROW_CYC);
            chk(frame_start == m_fs, "R4 frame_start", frame_start, m_fs);
            chk(frame_cnt == m_fr, "R4 frame_cnt", frame_cnt, m_fr);
            chk(frame_mark == m_mk, "R6 frame_mark", frame_mark, m_mk);
            if (frame_start && !edge_sync)
                chk(cyc - align_cyc == FRAME_CYC, "R5 frame period", cyc - align_cyc, FRAME_CYC);
        end
    end

    task automatic wait_cycles(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    initial begin
        logic [15:0] saved_cnt;
        bit strobe_seen;
        #1;
        wait_cycles(4);
        // R1 reset state
        chk(row_idx == 0 && frame_cnt == 0, "R1 reset counters", {row_idx, frame_cnt}, 0);
        chk(!frame_start && !frame_mark && !pix_tick && !row_tick, "R1 reset flags",
            {frame_start, frame_mark, pix_tick, row_tick}, 0);
        rst = 1'b0;

        // R3 first row step after 160 running edges
        wait_cycles(ROW_CYC);
        chk(row_idx == 1, "R3 first row step", row_idx, 1);
        chk(frame_mark == 0, "R6 no mark without frame", frame_mark, 0);

        // R4 natural wrap
        forever begin
            @(posedge clk); #1;
            if (frame_start) break;
        end
        chk(row_idx == 0, "R4 row at strobe", row_idx, 0);
        chk(frame_cnt == 1, "R4 count at strobe", frame_cnt, 1);
        chk(frame_mark == 1, "R6 mark at strobe", frame_mark, 1);
        wait_cycles(1);
        chk(frame_start == 0, "R4 strobe one cycle", frame_start, 0);

        // R8 hold mid-frame
        wait_cycles(300);
        saved_cnt = frame_cnt;
        hold_idle = 1'b1;
        wait_cycles(1);
        chk(row_idx == 0, "R8 hold row", row_idx, 0);
        chk(frame_cnt == saved_cnt, "R8 hold count kept", frame_cnt, saved_cnt);
        wait_cycles(49);
        chk(!pix_tick && !row_tick, "R8 no ticks in hold", {pix_tick, row_tick}, 0);
        hold_idle = 1'b0;
        strobe_seen = 0;
        for (int i = 0; i < ROW_CYC; i++) begin
            @(posedge clk); #1;
            if (frame_start) strobe_seen = 1;
        end
        chk(!strobe_seen, "R8 no strobe on release", strobe_seen, 0);
        chk(row_idx == 1, "R8 restart from phase 0", row_idx, 1);

        // R7 sync mid-frame
        wait_cycles(1000);
        sync_in = 1'b1;
        #1;
        chk(!pix_tick && !row_tick, "R7 ticks low in sync", {pix_tick, row_tick}, 0);
        wait_cycles(1);
        sync_in = 1'b0;
        chk(row_idx == 0 && frame_cnt == 0, "R7 sync clears", {row_idx, frame_cnt}, 0);
        chk(frame_start && frame_mark, "R7 sync strobe", {frame_start, frame_mark}, 3);
        wait_cycles(PIXD - 1);
        chk(pix_tick == 1, "R2 first pix tick after sync", pix_tick, 1);

        // R9 sync and hold together
        wait_cycles(2000);
        sync_in = 1'b1;
        hold_idle = 1'b1;
        wait_cycles(1);
        sync_in = 1'b0;
        chk(frame_start == 1 && frame_cnt == 0, "R9 sync wins", {frame_start, frame_cnt}, 17'h10000);
        wait_cycles(1);
        chk(frame_start == 0 && frame_mark == 0, "R9 then hold", {frame_start, frame_mark}, 0);
        hold_idle = 1'b0;

        // sync held two cycles
        wait_cycles(500);
        sync_in = 1'b1;
        wait_cycles(2);
        sync_in = 1'b0;
        chk(frame_start == 1, "R7 repeated sync strobe", frame_start, 1);
        wait_cycles(1000);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #(4 * 200000);
        if (!done) begin
            done = 1'b1;
            n_tests++;
            n_fail++;
            $display("FAIL watchdog expired: actual 1 expected 0");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule